// File: doc/BRIEF.md
# Superscalar Issue Window Controller

This block holds a small window of decoded instructions and decides, each cycle, which of them may be sent to the execution units. Every window entry carries an optional destination register, up to two optional source registers and a tag. An entry may issue only when it has no read-after-write, write-after-write or write-after-read conflict with an older entry still in the window, and none with a result still in flight. Registers are not renamed, so the two false dependence kinds block issue just as the true one does. In-flight results are tracked by a scoreboard with one busy bit per architectural register. The bit is set when a writer issues and cleared through a write-back port.

Two mode inputs shape the behaviour. The ordering mode chooses strict program order, where issue stops at the first entry that cannot go, or free selection, where any ready entry may issue. The refill mode chooses block refill, where a fresh window is taken only once the whole window has drained, or sliding refill, where the entries that remain move down to the lowest slots and freed slots are offered to the front end at once. The block reports per-slot grants, the number issued and how many new instructions it will accept this cycle. A flush input empties the window and leaves the scoreboard as it is.

Top module: `iw_issue_ctrl`

## Requirements
- R1: After reset the window is empty. No grant is set, issue_cnt is 0 and refill_cnt equals the window width W.
- R2: An entry whose valid source matches the valid destination of an older entry in the window does not issue. In strict mode, with the younger directly behind the older, only the older issues.
- R3: An entry with a valid destination does not issue while that register matches the valid destination of an older window entry, or while that register is busy in the scoreboard.
- R4: An entry with a valid destination does not issue while an older window entry reads that register through a valid source.
- R5: An entry does not issue while one of its valid sources is busy. A write-back of that register in the same cycle (wb_vld=1, wb_reg) counts as already cleared, so the entry may issue in that cycle.
- R6: Issuing an entry with a valid destination marks that register busy from the next cycle until it is written back. A destination or source field whose valid bit is 0 takes part in no hazard check.
- R7: With inorder_mode=1, no entry issues once an older entry in the window cannot issue.
- R8: With inorder_mode=0, every entry free of hazards issues in the same cycle, including entries younger than a blocked one.
- R9: With aligned_mode=1, refill_cnt is W when the window is empty and 0 otherwise. Fill ports are accepted only while refill_cnt is nonzero.
- R10: Slot 0 holds the oldest entry. With aligned_mode=0, refill_cnt equals W minus the number of occupied slots. At the clock edge the entries that did not issue move down to the lowest slots in their original order. Each fill port k with k < refill_cnt and fill_vld[k]=1 is then appended in port order. Entries loaded at an edge can issue from the next cycle.
- R11: Bit i of issue_grant refers to slot i and is set only for an occupied slot. issue_cnt equals the number of grant bits set, every cycle.
- R12: While flush=1, no grant is set and no fill is taken. The window is empty in the next cycle, and scoreboard busy bits are unchanged apart from write-back clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Empty the window, suppress grants this cycle |
| aligned_mode | input | 1 | 1: block refill, 0: sliding refill |
| inorder_mode | input | 1 | 1: strict program order, 0: free selection |
| fill_vld | input | W | Fill port k carries an instruction |
| fill_dst_v | input | W | Fill port k destination valid |
| fill_dst | input | W*RW | Fill port k destination register, port k at bits k*RW upward |
| fill_s1_v | input | W | Fill port k first source valid |
| fill_s1 | input | W*RW | Fill port k first source register |
| fill_s2_v | input | W | Fill port k second source valid |
| fill_s2 | input | W*RW | Fill port k second source register |
| fill_tag | input | W*TW | Fill port k instruction tag |
| wb_vld | input | 1 | Write-back clears a busy bit this cycle |
| wb_reg | input | RW | Register being written back |
| issue_grant | output | W | Slot i issues this cycle |
| issue_tag | output | W*TW | Tag held in each slot |
| issue_cnt | output | CW | Number of grants this cycle |
| refill_req | output | 1 | refill_cnt is nonzero |
| refill_cnt | output | CW | Fill ports accepted at the coming edge |

## Verification
The assertions assume that the front end presents at most refill_cnt instructions, on the lowest fill ports. They also assume that write-back arrives only for a register that an issued writer made busy, and never twice for one issue. The stimulus keeps to this by releasing each busy register once, after the writer that set it. Fills are placed on ports from 0 upward. Some fills are left on the ports while refill_cnt is 0, so that the block can be seen to ignore them.

// File: rtl/iw_pkg.sv
package iw_pkg;

  localparam int unsigned MAX_WIDTH = 6;

  // population count over a vector no wider than the largest window
  function automatic logic [3:0] ones(input logic [7:0] v);
    logic [3:0] n;
    n = '0;
    for (int b = 0; b < 8; b++) n = n + {3'd0, v[b]};
    return n;
  endfunction

endpackage

// File: rtl/iw_scoreboard.sv
module iw_scoreboard #(
  parameter int unsigned NREG = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NREG-1:0] set_mask,
  input  logic            wb_vld,
  input  logic [$clog2(NREG)-1:0] wb_reg,
  output logic [NREG-1:0] busy
);

  logic [NREG-1:0] clr_mask;

  always_comb begin
    clr_mask = '0;
    if (wb_vld) clr_mask[wb_reg] = 1'b1;
  end

  // a new writer wins over a clear of the same register
  always_ff @(posedge clk) begin
    if (rst) busy <= '0;
    else     busy <= (busy & ~clr_mask) | set_mask;
  end

  p_set_busy_r6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((busy & $past(set_mask)) == $past(set_mask)));

  p_wb_clears_r5: assert property (@(posedge clk) disable iff (rst)
    (wb_vld && !set_mask[wb_reg]) |=> !busy[$past(wb_reg)]);

endmodule

// File: rtl/iw_hazard.sv
module iw_hazard #(
  parameter int unsigned W    = 4,
  parameter int unsigned NREG = 32,
  localparam int unsigned RW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [W-1:0]    slot_vld,
  input  logic [W-1:0]    slot_dv,
  input  logic [RW-1:0]   slot_dst [W],
  input  logic [W-1:0]    slot_s1v,
  input  logic [RW-1:0]   slot_s1  [W],
  input  logic [W-1:0]    slot_s2v,
  input  logic [RW-1:0]   slot_s2  [W],
  input  logic [NREG-1:0] busy,
  input  logic            wb_vld,
  input  logic [RW-1:0]   wb_reg,
  input  logic [W-1:0]    grant,
  output logic [W-1:0]    ready
);

  logic [NREG-1:0] busy_eff;

  always_comb begin
    busy_eff = busy;
    if (wb_vld) busy_eff[wb_reg] = 1'b0;
  end

  for (genvar i = 0; i < W; i++) begin : g_slot
    logic haz;
    always_comb begin
      haz = 1'b0;
      if (slot_s1v[i] && busy_eff[slot_s1[i]]) haz = 1'b1;
      if (slot_s2v[i] && busy_eff[slot_s2[i]]) haz = 1'b1;
      if (slot_dv[i]  && busy_eff[slot_dst[i]]) haz = 1'b1;
      for (int j = 0; j < i; j++) begin
        if (slot_vld[j]) begin
          // true dependence on an older writer
          if (slot_dv[j] && slot_s1v[i] && slot_dst[j] == slot_s1[i]) haz = 1'b1;
          if (slot_dv[j] && slot_s2v[i] && slot_dst[j] == slot_s2[i]) haz = 1'b1;
          // output dependence
          if (slot_dv[j] && slot_dv[i] && slot_dst[j] == slot_dst[i]) haz = 1'b1;
          // anti dependence on an older reader
          if (slot_dv[i] && slot_s1v[j] && slot_s1[j] == slot_dst[i]) haz = 1'b1;
          if (slot_dv[i] && slot_s2v[j] && slot_s2[j] == slot_dst[i]) haz = 1'b1;
        end
      end
      ready[i] = slot_vld[i] && !haz;
    end

    p_src_free_r5: assert property (@(posedge clk) disable iff (rst)
      (grant[i] && slot_s1v[i]) |-> (!busy[slot_s1[i]] || (wb_vld && wb_reg == slot_s1[i])));
  end

endmodule

// File: rtl/iw_select.sv
module iw_select #(
  parameter int unsigned W  = 4,
  localparam int unsigned CW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  ready,
  input  logic          inorder_mode,
  input  logic          flush,
  output logic [W-1:0]  grant,
  output logic [CW-1:0] cnt
);

  import iw_pkg::*;

  logic blocked;

  always_comb begin
    blocked = 1'b0;
    for (int i = 0; i < W; i++) begin
      grant[i] = ready[i] && !flush && !(inorder_mode && blocked);
      if (!ready[i]) blocked = 1'b1;
    end
    cnt = CW'(ones(8'(grant)));
  end

  for (genvar i = 0; i + 1 < W; i++) begin : g_ord
    p_strict_order_r7: assert property (@(posedge clk) disable iff (rst)
      (inorder_mode && !grant[i]) |-> !grant[i+1]);
  end

endmodule

// File: rtl/iw_window.sv
module iw_window #(
  parameter int unsigned W   = 4,
  parameter int unsigned RW  = 5,
  parameter int unsigned TW  = 4,
  localparam int unsigned CW = $clog2(W + 1),
  localparam int unsigned IW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          aligned_mode,
  input  logic [W-1:0]  grant,
  input  logic [W-1:0]  fill_vld,
  input  logic [W-1:0]  fill_dv,
  input  logic [RW-1:0] fill_dst [W],
  input  logic [W-1:0]  fill_s1v,
  input  logic [RW-1:0] fill_s1  [W],
  input  logic [W-1:0]  fill_s2v,
  input  logic [RW-1:0] fill_s2  [W],
  input  logic [TW-1:0] fill_tag [W],
  output logic [W-1:0]  slot_vld,
  output logic [W-1:0]  slot_dv,
  output logic [RW-1:0] slot_dst [W],
  output logic [W-1:0]  slot_s1v,
  output logic [RW-1:0] slot_s1  [W],
  output logic [W-1:0]  slot_s2v,
  output logic [RW-1:0] slot_s2  [W],
  output logic [TW-1:0] slot_tag [W],
  output logic [CW-1:0] occ,
  output logic [CW-1:0] refill_cnt
);

  import iw_pkg::*;

  typedef struct packed {
    logic          vld;
    logic          dv;
    logic [RW-1:0] dst;
    logic          s1v;
    logic [RW-1:0] s1;
    logic          s2v;
    logic [RW-1:0] s2;
    logic [TW-1:0] tag;
  } ent_t;

  ent_t win [W];
  ent_t nxt [W];
  ent_t fin [W];

  for (genvar k = 0; k < W; k++) begin : g_io
    assign fin[k] = '{vld: fill_vld[k], dv: fill_dv[k], dst: fill_dst[k],
                      s1v: fill_s1v[k], s1: fill_s1[k], s2v: fill_s2v[k],
                      s2: fill_s2[k], tag: fill_tag[k]};
    assign slot_vld[k] = win[k].vld;
    assign slot_dv[k]  = win[k].dv;
    assign slot_dst[k] = win[k].dst;
    assign slot_s1v[k] = win[k].s1v;
    assign slot_s1[k]  = win[k].s1;
    assign slot_s2v[k] = win[k].s2v;
    assign slot_s2[k]  = win[k].s2;
    assign slot_tag[k] = win[k].tag;
  end

  assign occ = CW'(ones(8'(slot_vld)));

  always_comb begin
    if (aligned_mode) refill_cnt = (occ == '0) ? CW'(W) : '0;
    else              refill_cnt = CW'(W) - occ;
  end

  // survivors slide down in order, accepted fills follow them
  always_comb begin
    logic [CW-1:0] k;
    k = '0;
    for (int i = 0; i < W; i++) nxt[i] = '0;
    if (!flush) begin
      for (int i = 0; i < W; i++) begin
        if (win[i].vld && !grant[i] && k < CW'(W)) begin
          nxt[k[IW-1:0]] = win[i];
          k = k + CW'(1);
        end
      end
      for (int f = 0; f < W; f++) begin
        if (CW'(f) < refill_cnt && fin[f].vld && k < CW'(W)) begin
          nxt[k[IW-1:0]] = fin[f];
          k = k + CW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < W; i++) begin
      if (rst) win[i] <= '0;
      else     win[i] <= nxt[i];
    end
  end

  p_room_r10: assert property (@(posedge clk) disable iff (rst)
    (32'(occ) + 32'(refill_cnt)) <= W);

  p_flush_empty_r12: assert property (@(posedge clk) disable iff (rst)
    flush |=> (slot_vld == '0));

endmodule

// File: rtl/iw_issue_ctrl.sv
module iw_issue_ctrl #(
  parameter int unsigned W    = 4,
  parameter int unsigned NREG = 32,
  parameter int unsigned TW   = 4,
  localparam int unsigned RW  = $clog2(NREG),
  localparam int unsigned CW  = $clog2(W + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            flush,
  input  logic            aligned_mode,
  input  logic            inorder_mode,
  input  logic [W-1:0]    fill_vld,
  input  logic [W-1:0]    fill_dst_v,
  input  logic [W*RW-1:0] fill_dst,
  input  logic [W-1:0]    fill_s1_v,
  input  logic [W*RW-1:0] fill_s1,
  input  logic [W-1:0]    fill_s2_v,
  input  logic [W*RW-1:0] fill_s2,
  input  logic [W*TW-1:0] fill_tag,
  input  logic            wb_vld,
  input  logic [RW-1:0]   wb_reg,
  output logic [W-1:0]    issue_grant,
  output logic [W*TW-1:0] issue_tag,
  output logic [CW-1:0]   issue_cnt,
  output logic            refill_req,
  output logic [CW-1:0]   refill_cnt
);

  logic [RW-1:0]   f_dst [W];
  logic [RW-1:0]   f_s1  [W];
  logic [RW-1:0]   f_s2  [W];
  logic [TW-1:0]   f_tag [W];
  logic [W-1:0]    s_vld, s_dv, s_s1v, s_s2v, ready;
  logic [RW-1:0]   s_dst [W];
  logic [RW-1:0]   s_s1  [W];
  logic [RW-1:0]   s_s2  [W];
  logic [TW-1:0]   s_tag [W];
  logic [CW-1:0]   occ;
  logic [NREG-1:0] busy, set_mask;

  for (genvar k = 0; k < W; k++) begin : g_unpack
    assign f_dst[k] = fill_dst[k*RW +: RW];
    assign f_s1[k]  = fill_s1[k*RW +: RW];
    assign f_s2[k]  = fill_s2[k*RW +: RW];
    assign f_tag[k] = fill_tag[k*TW +: TW];
    assign issue_tag[k*TW +: TW] = s_tag[k];
  end

  always_comb begin
    set_mask = '0;
    for (int i = 0; i < W; i++)
      if (issue_grant[i] && s_dv[i]) set_mask[s_dst[i]] = 1'b1;
  end

  assign refill_req = (refill_cnt != '0);

  iw_window #(.W(W), .RW(RW), .TW(TW)) i_window (
    .clk, .rst, .flush, .aligned_mode,
    .grant(issue_grant),
    .fill_vld, .fill_dv(fill_dst_v), .fill_dst(f_dst),
    .fill_s1v(fill_s1_v), .fill_s1(f_s1),
    .fill_s2v(fill_s2_v), .fill_s2(f_s2), .fill_tag(f_tag),
    .slot_vld(s_vld), .slot_dv(s_dv), .slot_dst(s_dst),
    .slot_s1v(s_s1v), .slot_s1(s_s1), .slot_s2v(s_s2v), .slot_s2(s_s2),
    .slot_tag(s_tag), .occ, .refill_cnt
  );

  iw_hazard #(.W(W), .NREG(NREG)) i_hazard (
    .clk, .rst,
    .slot_vld(s_vld), .slot_dv(s_dv), .slot_dst(s_dst),
    .slot_s1v(s_s1v), .slot_s1(s_s1), .slot_s2v(s_s2v), .slot_s2(s_s2),
    .busy, .wb_vld, .wb_reg, .grant(issue_grant), .ready
  );

  iw_select #(.W(W)) i_select (
    .clk, .rst, .ready, .inorder_mode, .flush,
    .grant(issue_grant), .cnt(issue_cnt)
  );

  iw_scoreboard #(.NREG(NREG)) i_scoreboard (
    .clk, .rst, .set_mask, .wb_vld, .wb_reg, .busy
  );

  for (genvar i = 0; i < W; i++) begin : g_chk
    p_grant_occupied_r11: assert property (@(posedge clk) disable iff (rst)
      issue_grant[i] |-> s_vld[i]);
  end

  p_cnt_bound_r11: assert property (@(posedge clk) disable iff (rst)
    issue_cnt <= occ);

endmodule

// File: tb/test_iw_issue_ctrl.sv
`timescale 1ns/1ps
module test_iw_issue_ctrl;

  localparam int W = 4, NREG = 32, TW = 4, RW = 5, CW = 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, flush, aligned_mode, inorder_mode, wb_vld;
  logic [W-1:0] fill_vld, fill_dst_v, fill_s1_v, fill_s2_v;
  logic [W*RW-1:0] fill_dst, fill_s1, fill_s2;
  logic [W*TW-1:0] fill_tag;
  logic [RW-1:0] wb_reg;
  logic [W-1:0] issue_grant;
  logic [W*TW-1:0] issue_tag;
  logic [CW-1:0] issue_cnt, refill_cnt;
  logic refill_req;

  iw_issue_ctrl #(.W(W), .NREG(NREG), .TW(TW)) i_iw_issue_ctrl (.*);

  int checks = 0, fails = 0;
  bit done = 0;
  string q_req[$];
  logic [W-1:0] q_g[$];
  int q_c[$];
  int q_r[$];

  // monitor: compares one expected item per cycle, mid low phase
  initial forever begin
    @(negedge clk);
    #1;
    if (q_req.size() > 0) begin
      string rq; logic [W-1:0] g; int c, r;
      rq = q_req.pop_front(); g = q_g.pop_front();
      c = q_c.pop_front(); r = q_r.pop_front();
      checks++;
      if (issue_grant !== g || int'(issue_cnt) != c || int'(refill_cnt) != r ||
          refill_req !== (r != 0)) begin
        fails++;
        $display("FAIL %s grant=%b/%b cnt=%0d/%0d refill=%0d/%0d req=%b",
                 rq, issue_grant, g, issue_cnt, c, refill_cnt, r, refill_req);
      end
    end
  end

  task automatic clr_fill();
    fill_vld = '0; fill_dst_v = '0; fill_s1_v = '0; fill_s2_v = '0;
    fill_dst = '0; fill_s1 = '0; fill_s2 = '0; fill_tag = '0;
  endtask

  task automatic put(input int k, input bit dv, input int d, input bit s1v, input int s1,
                     input bit s2v, input int s2, input int tag);
    fill_vld[k] = 1'b1; fill_dst_v[k] = dv; fill_s1_v[k] = s1v; fill_s2_v[k] = s2v;
    fill_dst[k*RW +: RW] = RW'(d); fill_s1[k*RW +: RW] = RW'(s1);
    fill_s2[k*RW +: RW] = RW'(s2); fill_tag[k*TW +: TW] = TW'(tag);
  endtask

  // driver: inputs already set for this cycle; queue expectation, advance
  task automatic cyc(input string rq, input bit fl, input bit wbv, input int wbr,
                     input logic [W-1:0] g, input int c, input int r);
    flush = fl; wb_vld = wbv; wb_reg = RW'(wbr);
    q_req.push_back(rq); q_g.push_back(g); q_c.push_back(c); q_r.push_back(r);
    @(negedge clk);
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; flush = 0; wb_vld = 0; wb_reg = '0;
    aligned_mode = 0; inorder_mode = 1; clr_fill();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cyc("R1 reset empty", 0, 0, 0, 4'b0000, 0, 4);
    // four independent writers, all issue together
    put(0,1,1,1,2,1,3,0); put(1,1,4,1,5,1,6,1); put(2,1,7,1,8,1,9,2); put(3,1,10,1,11,1,12,3);
    cyc("R10 load", 0, 0, 0, 4'b0000, 0, 4);
    clr_fill();
    cyc("R8 R11 all ready", 0, 0, 0, 4'b1111, 4, 0);
    // A reads busy r1, B independent
    put(0,1,13,1,1,0,0,4); put(1,1,14,1,2,1,3,5);
    cyc("R10 load pair", 0, 0, 0, 4'b0000, 0, 4);
    clr_fill();
    cyc("R7 strict stops at blocked", 0, 0, 0, 4'b0000, 0, 2);
    inorder_mode = 0;
    cyc("R8 younger passes blocked", 0, 0, 0, 4'b0010, 1, 2);
    cyc("R5 same-cycle writeback", 0, 1, 1, 4'b0001, 1, 3);
    // intra-window RAW
    inorder_mode = 1;
    put(0,1,20,1,21,0,0,6); put(1,1,22,1,20,0,0,7);
    cyc("R10 load RAW pair", 0, 0, 0, 4'b0000, 0, 4);
    clr_fill();
    cyc("R2 only older issues", 0, 0, 0, 4'b0001, 1, 2);
    cyc("R5 source busy", 0, 0, 0, 4'b0000, 0, 3);
    cyc("R10 compacted entry issues", 0, 1, 20, 4'b0001, 1, 3);
    // WAW and WAR inside the window
    inorder_mode = 0;
    put(0,1,24,1,25,0,0,8); put(1,1,24,1,26,0,0,9); put(2,1,25,1,28,0,0,10); put(3,1,29,1,30,0,0,11);
    cyc("R10 load hazards", 0, 0, 0, 4'b0000, 0, 4);
    clr_fill();
    cyc("R3 R4 false deps block", 0, 0, 0, 4'b1001, 2, 0);
    cyc("R3 inflight WAW", 0, 0, 0, 4'b0010, 1, 2);
    cyc("R3 WAW released", 0, 1, 24, 4'b0001, 1, 3);
    // invalid destination / invalid source create no hazard
    inorder_mode = 1;
    put(0,0,6,1,2,1,3,12); put(1,1,6,1,8,0,0,13); put(2,1,11,0,6,0,0,14);
    cyc("R10 load store", 0, 0, 0, 4'b0000, 0, 4);
    clr_fill();
    cyc("R6 invalid fields ignored", 0, 0, 0, 4'b0111, 3, 1);
    // block refill
    aligned_mode = 1; inorder_mode = 0;
    put(0,1,15,1,4,0,0,1); put(1,1,16,0,0,0,0,2);
    cyc("R9 load empty", 0, 0, 0, 4'b0000, 0, 4);
    clr_fill(); put(0,1,17,0,0,0,0,3);
    cyc("R9 no refill while occupied", 0, 0, 0, 4'b0010, 1, 0);
    cyc("R9 fill ignored", 0, 0, 0, 4'b0000, 0, 0);
    cyc("R9 drain last", 0, 1, 4, 4'b0001, 1, 0);
    cyc("R9 reload when empty", 0, 0, 0, 4'b0000, 0, 4);
    clr_fill();
    cyc("R9 only one loaded", 0, 0, 0, 4'b0001, 1, 0);
    // sliding refill
    aligned_mode = 0;
    put(0,1,18,1,7,0,0,4); put(1,1,19,0,0,0,0,5); put(2,1,21,0,0,0,0,6); put(3,1,23,0,0,0,0,7);
    cyc("R10 load slide", 0, 0, 0, 4'b0000, 0, 4);
    clr_fill(); put(0,1,26,0,0,0,0,8);
    cyc("R8 three issue, fill refused", 0, 0, 0, 4'b1110, 3, 0);
    cyc("R10 freed slots offered", 0, 0, 0, 4'b0000, 0, 3);
    clr_fill();
    cyc("R10 appended after survivor", 0, 0, 0, 4'b0010, 1, 2);
    // flush
    put(0,1,27,0,0,0,0,9);
    cyc("R12 flush suppresses grants", 1, 0, 0, 4'b0000, 0, 3);
    clr_fill();
    cyc("R12 window empty", 0, 0, 0, 4'b0000, 0, 4);
    put(0,1,28,1,19,0,0,10);
    cyc("R12 load after flush", 0, 0, 0, 4'b0000, 0, 4);
    clr_fill();
    cyc("R12 scoreboard kept", 0, 0, 0, 4'b0000, 0, 3);
    cyc("R5 release after flush", 0, 1, 19, 4'b0001, 1, 3);
    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule